// File: doc/BRIEF.md
# Embedded-Clock Serial Frame Decoder

This block sits behind a clock-and-data recovery front end. It takes one recovered serial bit per cycle of a bit clock that runs at 28 times the pixel rate. The serial stream is made of 28-bit frames. Each frame carries a fixed one-then-zero clock-bit pair, an inversion flag, a parity bit and a 24-bit payload. The decoder finds the frame phase from the clock-bit pair alone. It needs no training pattern and no reference clock. Once locked, it restores each payload that was sent inverted, checks the parity bit, and presents the word once per frame as a one-cycle strobe together with a named split into colour, sync and side bits.

The output is a push-only stream. The serial link cannot be paused, so there is no ready input and no back-pressure. Each word stays stable on the port until the next good frame, which is 28 bit-clock cycles later. A sink must take the word within that window. A lock flag reports frame alignment. A stream-stopped flag rises when alignment is lost because the clock pair disappeared, and it clears when lock is regained.

Top module: `serial_frame_decoder`

## Requirements
- R1: Arrival order within a frame is clock-one (1), clock-zero (0), inversion flag, parity bit, then payload bit 23 down to bit 0. From any starting bit offset and on random payloads, `locked` rises on the cycle that samples the last bit of the 8th consecutive frame showing the 1/0 pair at the same offset, and not before.
- R2: After reset every output is 0. `word_valid` is never high while `locked` is low, and the frame that completes lock produces no strobe.
- R3: When the inversion flag of a frame is 1, `word_data` is the bitwise inverse of the received payload bits; when it is 0, they pass unchanged.
- R4: Parity is even over the inversion flag, the parity bit and the 24 payload bits as sent. A locked frame that fails parity pulses `word_bad` for one cycle, raises no `word_valid`, and leaves `word_data` unchanged.
- R5: While locked, `locked` falls on the cycle that samples the last bit of the 4th consecutive frame slot missing the 1/0 pair. Three missing slots are tolerated, and a good frame restarts the count.
- R6: `stream_stopped` rises together with the fall of `locked` caused by R5, stays high while hunting, and clears when lock is reacquired. It is never high while `locked` is high.
- R7: Field split of `word_data`: red = bits 5:0, green = 11:6, blue = 17:12, line sync = 18, frame sync = 19, data enable = 20, side bits = 23:21.
- R8: After a loss of lock, the decoder locks again by the rule of R1 at a new bit offset.
- R9: Each good locked frame gives exactly one `word_valid` cycle, visible after the edge that samples its last bit. `word_data` changes only on such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 28 cycles per frame |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Recovered serial bit, one per cycle |
| locked | output | 1 | Frame alignment held |
| stream_stopped | output | 1 | Alignment lost because clock pairs disappeared |
| word_valid | output | 1 | One-cycle strobe for a good decoded frame |
| word_bad | output | 1 | One-cycle strobe for a locked frame that failed parity |
| word_data | output | 24 | Decoded payload, held between strobes |
| pix_red | output | 6 | Red colour field |
| pix_green | output | 6 | Green colour field |
| pix_blue | output | 6 | Blue colour field |
| line_sync | output | 1 | Line sync bit |
| frame_sync | output | 1 | Frame sync bit |
| data_en | output | 1 | Data enable bit |
| side_bits | output | 3 | Low-rate side bits |

## Verification
A wrong frame phase shows up as parity strobes and scrambled words on the first strobe after lock, which comes 28 cycles after `locked` rises. A stale hunt counter changes the cycle on which `locked` rises, and the bench checks that cycle to the frame. A miss counter that is wrong or fails to restart moves the fall of `locked` by one or more whole frames. The bench catches this at the three-slot and four-slot boundaries. A bad inversion or parity path corrupts `word_data` or swaps `word_valid` with `word_bad` on the same cycle.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int unsigned COLOR_W = 6;
  localparam int unsigned CTRL_W  = 3;
  localparam int unsigned SIDE_W  = 3;
  localparam int unsigned PAY_W   = 3 * COLOR_W + CTRL_W + SIDE_W;
  localparam int unsigned OVH_W   = 4;
  localparam int unsigned FRAME_W = PAY_W + OVH_W;

  // packed order: first member is most significant
  typedef struct packed {
    logic [SIDE_W-1:0]  side;
    logic               den;
    logic               vsy;
    logic               hsy;
    logic [COLOR_W-1:0] blu;
    logic [COLOR_W-1:0] grn;
    logic [COLOR_W-1:0] red;
  } pixel_t;
endpackage

// File: rtl/sfd_align.sv
module sfd_align
  import sfd_pkg::*;
#(
  parameter int unsigned LOCK_FRAMES = 8,
  parameter int unsigned LOSS_FRAMES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_bit,
  output logic [PAY_W+1:0] body,
  output logic             pair_seen,
  output logic             frame_tick,
  output logic             locked,
  output logic             stopped
);
  localparam int unsigned PH_W   = $clog2(FRAME_W);
  localparam int unsigned HUNT_W = $clog2(LOCK_FRAMES + 1);
  localparam int unsigned MISS_W = $clog2(LOSS_FRAMES + 1);

  logic [FRAME_W-2:0] hist_q;
  logic [FRAME_W-1:0] window;
  logic [PH_W-1:0]    ph_q, phase_q;
  logic [MISS_W-1:0]  miss_q;
  logic [FRAME_W-1:0] at_ph, near_full;
  logic               locked_q, stopped_q, acquire, lose;

  assign window     = {hist_q, ser_bit};
  assign body       = window[PAY_W+1:0];
  assign pair_seen  = window[FRAME_W-1] & ~window[FRAME_W-2];
  assign frame_tick = locked_q && (ph_q == phase_q);
  assign acquire    = !locked_q && pair_seen && |(at_ph & near_full);
  assign lose       = frame_tick && !pair_seen &&
                      (miss_q == MISS_W'(LOSS_FRAMES - 1));
  assign locked     = locked_q;
  assign stopped    = stopped_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      ph_q   <= '0;
    end else begin
      hist_q <= window[FRAME_W-2:0];
      ph_q   <= (ph_q == PH_W'(FRAME_W - 1)) ? '0 : ph_q + 1'b1;
    end
  end

  // one run-length counter per candidate bit offset
  for (genvar g = 0; g < FRAME_W; g++) begin : g_hunt
    logic [HUNT_W-1:0] run_q;
    assign at_ph[g]     = (ph_q == PH_W'(g));
    assign near_full[g] = (run_q == HUNT_W'(LOCK_FRAMES - 1));
    always_ff @(posedge clk) begin
      if (!rst_n || lose)
        run_q <= '0;
      else if (!locked_q && at_ph[g])
        run_q <= pair_seen ? run_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q  <= 1'b0;
      stopped_q <= 1'b0;
      phase_q   <= '0;
      miss_q    <= '0;
    end else if (acquire) begin
      locked_q  <= 1'b1;
      stopped_q <= 1'b0;
      phase_q   <= ph_q;
      miss_q    <= '0;
    end else if (lose) begin
      locked_q  <= 1'b0;
      stopped_q <= 1'b1;
      miss_q    <= '0;
    end else if (frame_tick) begin
      miss_q <= pair_seen ? '0 : miss_q + 1'b1;
    end
  end

  a_r1_lock_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(pair_seen));
  a_r5_drop_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(!pair_seen));
  a_r6_stop_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> stopped_q);
  a_r6_lock_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked_q && stopped_q));
endmodule

// File: rtl/sfd_frame.sv
module sfd_frame
  import sfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAY_W+1:0] body,
  input  logic             frame_tick,
  input  logic             pair_seen,
  input  logic             locked,
  output logic             word_valid,
  output logic             word_bad,
  output logic [PAY_W-1:0] word_data
);
  localparam int unsigned INV_POS = PAY_W + 1;

  logic take, parity_ok;

  assign take      = frame_tick & pair_seen;
  assign parity_ok = ~(^body);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_bad   <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= take & parity_ok;
      word_bad   <= take & ~parity_ok;
      if (take && parity_ok)
        word_data <= body[PAY_W-1:0] ^ {PAY_W{body[INV_POS]}};
    end
  end

  a_r2_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> locked);
  a_r4_valid_bad_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && word_bad));
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  a_r9_data_moves_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_data) |-> word_valid);
endmodule

// File: rtl/sfd_fields.sv
module sfd_fields
  import sfd_pkg::*;
(
  input  logic [PAY_W-1:0]   word,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue,
  output logic               hsy,
  output logic               vsy,
  output logic               den,
  output logic [SIDE_W-1:0]  side
);
  pixel_t px;

  assign px    = pixel_t'(word);
  assign red   = px.red;
  assign green = px.grn;
  assign blue  = px.blu;
  assign hsy   = px.hsy;
  assign vsy   = px.vsy;
  assign den   = px.den;
  assign side  = px.side;
endmodule

// File: rtl/serial_frame_decoder.sv
module serial_frame_decoder
  import sfd_pkg::*;
#(
  parameter int unsigned LOCK_FRAMES = 8,
  parameter int unsigned LOSS_FRAMES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_bit,
  output logic               locked,
  output logic               stream_stopped,
  output logic               word_valid,
  output logic               word_bad,
  output logic [PAY_W-1:0]   word_data,
  output logic [COLOR_W-1:0] pix_red,
  output logic [COLOR_W-1:0] pix_green,
  output logic [COLOR_W-1:0] pix_blue,
  output logic               line_sync,
  output logic               frame_sync,
  output logic               data_en,
  output logic [SIDE_W-1:0]  side_bits
);
  logic [PAY_W+1:0] body;
  logic             pair_seen, frame_tick;

  sfd_align #(
    .LOCK_FRAMES(LOCK_FRAMES),
    .LOSS_FRAMES(LOSS_FRAMES)
  ) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_bit    (ser_bit),
    .body       (body),
    .pair_seen  (pair_seen),
    .frame_tick (frame_tick),
    .locked     (locked),
    .stopped    (stream_stopped)
  );

  sfd_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .body       (body),
    .frame_tick (frame_tick),
    .pair_seen  (pair_seen),
    .locked     (locked),
    .word_valid (word_valid),
    .word_bad   (word_bad),
    .word_data  (word_data)
  );

  sfd_fields u_fields (
    .word  (word_data),
    .red   (pix_red),
    .green (pix_green),
    .blue  (pix_blue),
    .hsy   (line_sync),
    .vsy   (frame_sync),
    .den   (data_en),
    .side  (side_bits)
  );
endmodule

// File: tb/tb_serial_frame_decoder.sv
module tb_serial_frame_decoder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, ser_bit;
  logic        locked, stream_stopped, word_valid, word_bad;
  logic [23:0] word_data;
  logic [5:0]  pix_red, pix_green, pix_blue;
  logic        line_sync, frame_sync, data_en;
  logic [2:0]  side_bits;

  serial_frame_decoder dut (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit),
    .locked(locked), .stream_stopped(stream_stopped),
    .word_valid(word_valid), .word_bad(word_bad), .word_data(word_data),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
    .line_sync(line_sync), .frame_sync(frame_sync), .data_en(data_en),
    .side_bits(side_bits)
  );

  int errors = 0;
  int checks = 0;
  int n_valid = 0;
  int n_bad = 0;
  logic [23:0] exp_word = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe monitor: payload of each strobe against the last good frame sent
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (word_valid) begin
        n_valid++;
        chk(word_data == exp_word, "R3 strobe payload", {8'h0, word_data}, {8'h0, exp_word});
      end
      if (word_bad) n_bad++;
    end
  end

  task automatic send_frame(input logic [23:0] p, input bit inv, input bit corrupt);
    logic [23:0] s;
    logic        dca;
    logic [27:0] f;
    s   = inv ? ~p : p;
    dca = (^{inv, s}) ^ corrupt;
    f   = {1'b1, 1'b0, inv, dca, s};
    for (int i = 27; i >= 0; i--) begin
      @(negedge clk);
      ser_bit = f[i];
    end
    if (!corrupt) exp_word = p;
  endtask

  task automatic send_rand();
    logic [23:0] p;
    p = 24'($urandom);
    send_frame(p, 1'($urandom), 1'b0);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_bit = 1'b0;
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ser_bit = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(locked == 0, "R2 reset locked", 32'(locked), 0);
    chk(stream_stopped == 0, "R6 reset stopped", 32'(stream_stopped), 0);
    chk(word_valid == 0 && word_bad == 0, "R2 reset strobes", {word_valid, word_bad}, 0);
    chk(word_data == 0, "R2 reset data", 32'(word_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_acquire();
    send_zeros(5);
    n_valid = 0;
    for (int i = 0; i < 7; i++) send_rand();
    settle();
    chk(locked == 0, "R1 no lock after 7 frames", 32'(locked), 0);
    send_rand();
    settle();
    chk(locked == 1, "R1 lock on 8th frame", 32'(locked), 1);
    chk(n_valid == 0, "R2 no strobe before lock", n_valid, 0);
    for (int i = 0; i < 4; i++) send_rand();
    settle();
    chk(n_valid == 4, "R9 one strobe per frame", n_valid, 4);
    chk(n_bad == 0, "R4 no parity flags", n_bad, 0);
  endtask

  task automatic t_fields();
    logic [23:0] p;
    p = 24'hB5_3C_96;
    send_frame(p, 1'b1, 1'b0);
    settle();
    chk(word_valid == 1, "R9 strobe after inverted frame", 32'(word_valid), 1);
    chk(word_data == p, "R3 inverted payload restored", 32'(word_data), 32'(p));
    chk(pix_red == p[5:0], "R7 red", 32'(pix_red), 32'(p[5:0]));
    chk(pix_green == p[11:6], "R7 green", 32'(pix_green), 32'(p[11:6]));
    chk(pix_blue == p[17:12], "R7 blue", 32'(pix_blue), 32'(p[17:12]));
    chk({data_en, frame_sync, line_sync} == p[20:18], "R7 sync bits",
        {data_en, frame_sync, line_sync}, 32'(p[20:18]));
    chk(side_bits == p[23:21], "R7 side bits", 32'(side_bits), 32'(p[23:21]));
    p = 24'h4A_C3_69;
    send_frame(p, 1'b0, 1'b0);
    settle();
    chk(word_data == p, "R3 plain payload", 32'(word_data), 32'(p));
    chk(side_bits == p[23:21], "R7 side bits plain", 32'(side_bits), 32'(p[23:21]));
  endtask

  task automatic t_parity();
    logic [23:0] prev;
    prev = word_data;
    send_frame(24'h12_34_56, 1'b1, 1'b1);
    settle();
    chk(word_bad == 1, "R4 bad flag", 32'(word_bad), 1);
    chk(word_valid == 0, "R4 no strobe on bad frame", 32'(word_valid), 0);
    chk(word_data == prev, "R4 data held", 32'(word_data), 32'(prev));
    chk(locked == 1, "R4 lock kept", 32'(locked), 1);
    send_frame(24'h0F_F0_0F, 1'b0, 1'b0);
    settle();
    chk(word_valid == 1 && word_bad == 0, "R4 recovery strobe", {word_valid, word_bad}, 2);
  endtask

  task automatic t_glitch();
    send_zeros(3 * 28);
    settle();
    chk(locked == 1, "R5 three missing tolerated", 32'(locked), 1);
    send_rand();
    settle();
    chk(word_valid == 1, "R5 good frame after gap", 32'(word_valid), 1);
    send_zeros(3 * 28);
    settle();
    chk(locked == 1 && stream_stopped == 0, "R5 miss count restarted",
        {locked, stream_stopped}, 2);
    send_rand();
    settle();
  endtask

  task automatic t_stop();
    n_valid = 0;
    send_zeros(3 * 28);
    settle();
    chk(locked == 1, "R5 still locked after 3", 32'(locked), 1);
    send_zeros(28);
    settle();
    chk(locked == 0, "R5 lock lost after 4", 32'(locked), 0);
    chk(stream_stopped == 1, "R6 stopped raised", 32'(stream_stopped), 1);
    chk(n_valid == 0, "R2 no strobes while stopping", n_valid, 0);
  endtask

  task automatic t_relock();
    send_zeros(11);
    n_valid = 0;
    for (int i = 0; i < 7; i++) send_rand();
    settle();
    chk(locked == 0 && stream_stopped == 1, "R6 stopped held while hunting",
        {locked, stream_stopped}, 1);
    send_rand();
    settle();
    chk(locked == 1, "R8 relock at new offset", 32'(locked), 1);
    chk(stream_stopped == 0, "R6 stopped cleared", 32'(stream_stopped), 0);
    chk(n_valid == 0, "R2 no strobe during relock", n_valid, 0);
    for (int i = 0; i < 3; i++) send_rand();
    settle();
    chk(n_valid == 3, "R8 strobes after relock", n_valid, 3);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire();
    t_fields();
    t_parity();
    t_glitch();
    t_stop();
    t_relock();
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule